// File: doc/BRIEF.md
# Lease-Timed Shared Cache Coherence Controller

This block is the shared second-level cache controller for a group of first-level caches that keep themselves coherent by time rather than by messages. A first-level cache asks for a block together with a lease, which is the time up to which it intends to keep its copy. The controller keeps no list of holders. Each resident block carries one timestamp, the latest lease granted to anyone, and the controller reads this against a global time input. All first-level contents are also held here, so the timestamp of any block a first-level cache may still hold is always available.

A mode input selects what happens when a write reaches a block whose lease is still live. In strict mode the write is held at its port until global time has moved past the timestamp, so no stale reader copy can remain when it performs. While it is held, requests from other ports to the same block are also held, and requests to other blocks are still served. In relaxed mode the write performs at once, and the response carries the block's timestamp as the time by which the write is visible everywhere. The requester can then delay its own fences until that time.

Misses fetch the block through a simple fill interface. Only blocks whose lease has ended may be replaced, because a later write must still be able to find the lease. A victim that holds data is written out through a one-cycle writeback pulse.

Top module: `lease_l2_ctrl`

## Requirements
- R1: After reset no port is ready, no response is valid, `fill_req` is low and `wb_valid` is low.
- R2: When several eligible requests are present in one cycle, exactly one is accepted, and it is the one with the lowest port index.
- R3: A read that hits is accepted in its cycle. In the next cycle the port gives `rsp_valid` with the block data, and `rsp_time` equal to the larger of the block's old timestamp and the requested lease, which becomes the new timestamp.
- R4: A block is live when it has been leased and `now_time` is less than or equal to its timestamp. In strict mode (`strict_mode`=1) a write to a live block is not accepted until `now_time` exceeds the timestamp. It then performs and responds with `rsp_time` equal to `now_time` at acceptance.
- R5: In relaxed mode (`strict_mode`=0) a write that hits is accepted at once. The response carries the written data, and `rsp_time` is the block timestamp if the block is live, otherwise `now_time`.
- R6: While a strict-mode write is held on a block, requests from other ports to that same block address are not accepted, and requests to other blocks are still accepted.
- R7: A miss raises `fill_req` with `fill_addr` equal to the request address, held stable until `fill_valid`. No request is accepted while the fill is outstanding. The filled block then serves the waiting request, which reads the fill data.
- R8: The victim of a miss is the lowest-numbered empty way, otherwise the lowest-numbered way that is not live. If the victim held a block, `wb_valid` pulses for one cycle with that block's address and data.
- R9: If every way of the target set is live, the miss waits: no fill is requested and the request is not accepted until some way of that set stops being live.
- R10: A freshly filled block counts as not live until it is first leased, so a strict-mode write to it performs without waiting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| strict_mode | input | 1 | 1: hold writes on live blocks; 0: perform and return completion time |
| now_time | input | TIME_W | Global time |
| req_valid | input | PORTS | Request present, one bit per port |
| req_write | input | PORTS | 1 write, 0 lease read |
| req_addr | input | PORTS x ADDR_W | Block address; low SET_W bits select the set |
| req_lease | input | PORTS x TIME_W | Requested lease end time (reads) |
| req_wdata | input | PORTS x DATA_W | Write data |
| req_ready | output | PORTS | Request accepted this cycle |
| rsp_valid | output | PORTS | Response valid, one cycle after acceptance |
| rsp_data | output | PORTS x DATA_W | Read data, or the written data for writes |
| rsp_time | output | PORTS x TIME_W | Lease timestamp for reads, completion time for writes |
| fill_req | output | 1 | Fill outstanding |
| fill_addr | output | ADDR_W | Address being filled |
| fill_valid | input | 1 | Fill data present |
| fill_data | input | DATA_W | Fill data |
| wb_valid | output | 1 | Victim writeback pulse |
| wb_addr | output | ADDR_W | Victim address |
| wb_data | output | DATA_W | Victim data |

## Verification
The lease arithmetic is tried with leases that extend the timestamp, leases below it, and leases already in the past. These separate taking the maximum from simply overwriting the timestamp. Writes are issued to live blocks, to expired blocks and to freshly filled blocks in both modes, which shows whether the completion time or the stall follows the liveness rule, including the boundary where `now_time` equals the timestamp. A held strict write is combined with another port's requests to the same block and to a different block, which separates per-block holding from blocking the whole controller. A set filled with leases that end at different times shows whether the wait-for-victim rule and the lowest-expired-way choice are in place.

// File: rtl/lease_l2_pkg.sv
package lease_l2_pkg;
   typedef enum logic {
      CT_IDLE = 1'b0,
      CT_FILL = 1'b1
   } ctl_state_e;
endpackage

// File: rtl/lease_l2_prio.sv
// Fixed-priority pick: lowest index wins.
module lease_l2_prio #(
   parameter int N = 2
) (
   input  logic [N-1:0] req,
   output logic [N-1:0] gnt
);
   always_comb begin
      logic taken;
      taken = 1'b0;
      gnt   = '0;
      for (int i = 0; i < N; i++) begin
         if (req[i] && !taken) begin
            gnt[i] = 1'b1;
            taken  = 1'b1;
         end
      end
   end
endmodule

// File: rtl/lease_l2_probe.sv
// Looks up one set: hit way, lease liveness, and replacement candidate.
module lease_l2_probe #(
   parameter int WAYS   = 4,
   parameter int TAG_W  = 5,
   parameter int TIME_W = 16,
   parameter int DATA_W = 8,
   localparam int WAY_W = $clog2(WAYS)
) (
   input  logic [WAYS-1:0]             way_valid,
   input  logic [WAYS-1:0]             way_leased,
   input  logic [WAYS-1:0][TAG_W-1:0]  way_tag,
   input  logic [WAYS-1:0][TIME_W-1:0] way_ts,
   input  logic [WAYS-1:0][DATA_W-1:0] way_data,
   input  logic [TAG_W-1:0]            tag,
   input  logic [TIME_W-1:0]           now,
   output logic                        hit,
   output logic [WAY_W-1:0]            hit_way,
   output logic                        hit_live,
   output logic [TIME_W-1:0]           hit_ts,
   output logic [DATA_W-1:0]           hit_data,
   output logic                        vic_ok,
   output logic [WAY_W-1:0]            vic_way,
   output logic                        vic_used
);
   logic [WAYS-1:0] live;

   for (genvar w = 0; w < WAYS; w++) begin : g_live
      assign live[w] = way_valid[w] && way_leased[w] && (now <= way_ts[w]);
   end

   always_comb begin
      logic got_empty;
      logic got_stale;
      hit       = 1'b0;
      hit_way   = '0;
      got_empty = 1'b0;
      got_stale = 1'b0;
      vic_way   = '0;
      for (int w = WAYS-1; w >= 0; w--) begin
         if (way_valid[w] && way_tag[w] == tag) begin
            hit     = 1'b1;
            hit_way = WAY_W'(w);
         end
      end
      // empty ways take precedence over expired ones; lowest index inside each class
      for (int w = WAYS-1; w >= 0; w--) begin
         if (!way_valid[w]) begin
            got_empty = 1'b1;
            vic_way   = WAY_W'(w);
         end
      end
      if (!got_empty) begin
         for (int w = WAYS-1; w >= 0; w--) begin
            if (!live[w]) begin
               got_stale = 1'b1;
               vic_way   = WAY_W'(w);
            end
         end
      end
      vic_ok   = got_empty || got_stale;
      vic_used = !got_empty;
   end

   assign hit_live = hit && live[hit_way];
   assign hit_ts   = way_ts[hit_way];
   assign hit_data = way_data[hit_way];
endmodule

// File: rtl/lease_l2_ctrl.sv
module lease_l2_ctrl
   import lease_l2_pkg::*;
#(
   parameter int PORTS  = 2,
   parameter int SETS   = 8,
   parameter int WAYS   = 4,
   parameter int ADDR_W = 8,
   parameter int DATA_W = 8,
   parameter int TIME_W = 16
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          strict_mode,
   input  logic [TIME_W-1:0]             now_time,
   input  logic [PORTS-1:0]              req_valid,
   input  logic [PORTS-1:0]              req_write,
   input  logic [PORTS-1:0][ADDR_W-1:0]  req_addr,
   input  logic [PORTS-1:0][TIME_W-1:0]  req_lease,
   input  logic [PORTS-1:0][DATA_W-1:0]  req_wdata,
   output logic [PORTS-1:0]              req_ready,
   output logic [PORTS-1:0]              rsp_valid,
   output logic [PORTS-1:0][DATA_W-1:0]  rsp_data,
   output logic [PORTS-1:0][TIME_W-1:0]  rsp_time,
   output logic                          fill_req,
   output logic [ADDR_W-1:0]             fill_addr,
   input  logic                          fill_valid,
   input  logic [DATA_W-1:0]             fill_data,
   output logic                          wb_valid,
   output logic [ADDR_W-1:0]             wb_addr,
   output logic [DATA_W-1:0]             wb_data
);
   localparam int SET_W  = $clog2(SETS);
   localparam int TAG_W  = ADDR_W - SET_W;
   localparam int WAY_W  = $clog2(WAYS);
   localparam int PORT_W = $clog2(PORTS);

   if (PORTS < 2 || WAYS < 2 || SETS < 2 || (1 << SET_W) != SETS || TAG_W < 1) begin : g_bad_cfg
      initial $fatal(1, "lease_l2_ctrl: unsupported parameter set");
   end

   // block storage
   logic [SETS-1:0][WAYS-1:0]             valid_q, leased_q;
   logic [SETS-1:0][WAYS-1:0][TAG_W-1:0]  tag_q;
   logic [SETS-1:0][WAYS-1:0][TIME_W-1:0] ts_q;
   logic [SETS-1:0][WAYS-1:0][DATA_W-1:0] data_q;

   ctl_state_e         state_q;
   logic [SET_W-1:0]   fill_set_q;
   logic [TAG_W-1:0]   fill_tag_q;
   logic [WAY_W-1:0]   fill_way_q;

   // per-port lookup results
   logic [PORTS-1:0]              p_hit, p_live, p_vok, p_vused, p_stall, p_block, p_elig, grant;
   logic [PORTS-1:0][SET_W-1:0]   p_set;
   logic [PORTS-1:0][TAG_W-1:0]   p_tag;
   logic [PORTS-1:0][WAY_W-1:0]   p_way, p_vway;
   logic [PORTS-1:0][TIME_W-1:0]  p_ts;
   logic [PORTS-1:0][DATA_W-1:0]  p_data;

   for (genvar p = 0; p < PORTS; p++) begin : g_port
      assign p_set[p] = req_addr[p][SET_W-1:0];
      assign p_tag[p] = req_addr[p][ADDR_W-1:SET_W];

      lease_l2_probe #(
         .WAYS(WAYS), .TAG_W(TAG_W), .TIME_W(TIME_W), .DATA_W(DATA_W)
      ) u_probe (
         .way_valid (valid_q[p_set[p]]),
         .way_leased(leased_q[p_set[p]]),
         .way_tag   (tag_q[p_set[p]]),
         .way_ts    (ts_q[p_set[p]]),
         .way_data  (data_q[p_set[p]]),
         .tag       (p_tag[p]),
         .now       (now_time),
         .hit       (p_hit[p]),
         .hit_way   (p_way[p]),
         .hit_live  (p_live[p]),
         .hit_ts    (p_ts[p]),
         .hit_data  (p_data[p]),
         .vic_ok    (p_vok[p]),
         .vic_way   (p_vway[p]),
         .vic_used  (p_vused[p])
      );

      assign p_stall[p] = req_valid[p] && req_write[p] && strict_mode && p_live[p];
   end

   // a held strict write fences its block against every other port
   always_comb begin
      p_block = '0;
      for (int p = 0; p < PORTS; p++) begin
         for (int q = 0; q < PORTS; q++) begin
            if (q != p && p_stall[q] && req_addr[q] == req_addr[p]) p_block[p] = 1'b1;
         end
      end
   end

   assign p_elig = req_valid & ~p_stall & ~p_block & (p_hit | p_vok)
                 & {PORTS{state_q == CT_IDLE}};

   lease_l2_prio #(.N(PORTS)) u_prio (.req(p_elig), .gnt(grant));

   assign req_ready = grant & p_hit;

   logic [PORT_W-1:0] sel;
   logic [TIME_W-1:0] sel_new_ts;
   always_comb begin
      sel = '0;
      for (int p = PORTS-1; p >= 0; p--) if (grant[p]) sel = PORT_W'(p);
      sel_new_ts = (req_lease[sel] > p_ts[sel]) ? req_lease[sel] : p_ts[sel];
   end

   assign fill_req  = (state_q == CT_FILL);
   assign fill_addr = {fill_tag_q, fill_set_q};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q    <= CT_IDLE;
         valid_q    <= '0;
         leased_q   <= '0;
         tag_q      <= '0;
         ts_q       <= '0;
         data_q     <= '0;
         fill_set_q <= '0;
         fill_tag_q <= '0;
         fill_way_q <= '0;
         rsp_valid  <= '0;
         rsp_data   <= '0;
         rsp_time   <= '0;
         wb_valid   <= 1'b0;
         wb_addr    <= '0;
         wb_data    <= '0;
      end else begin
         rsp_valid <= '0;
         wb_valid  <= 1'b0;
         unique case (state_q)
            CT_IDLE: if (|grant) begin
               if (p_hit[sel]) begin
                  rsp_valid[sel] <= 1'b1;
                  if (req_write[sel]) begin
                     data_q[p_set[sel]][p_way[sel]] <= req_wdata[sel];
                     rsp_data[sel] <= req_wdata[sel];
                     rsp_time[sel] <= p_live[sel] ? p_ts[sel] : now_time;
                  end else begin
                     ts_q[p_set[sel]][p_way[sel]]     <= sel_new_ts;
                     leased_q[p_set[sel]][p_way[sel]] <= 1'b1;
                     rsp_data[sel] <= p_data[sel];
                     rsp_time[sel] <= sel_new_ts;
                  end
               end else begin
                  state_q    <= CT_FILL;
                  fill_set_q <= p_set[sel];
                  fill_tag_q <= p_tag[sel];
                  fill_way_q <= p_vway[sel];
                  valid_q[p_set[sel]][p_vway[sel]] <= 1'b0;
                  wb_valid <= p_vused[sel];
                  wb_addr  <= {tag_q[p_set[sel]][p_vway[sel]], p_set[sel]};
                  wb_data  <= data_q[p_set[sel]][p_vway[sel]];
               end
            end
            CT_FILL: if (fill_valid) begin
               valid_q[fill_set_q][fill_way_q]  <= 1'b1;
               leased_q[fill_set_q][fill_way_q] <= 1'b0;
               tag_q[fill_set_q][fill_way_q]    <= fill_tag_q;
               ts_q[fill_set_q][fill_way_q]     <= '0;
               data_q[fill_set_q][fill_way_q]   <= fill_data;
               state_q <= CT_IDLE;
            end
            default: state_q <= CT_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/lease_l2_chk.sv
module lease_l2_chk #(
   parameter int PORTS  = 2,
   parameter int ADDR_W = 8,
   parameter int TIME_W = 16
) (
   input logic                         clk,
   input logic                         rst_n,
   input logic                         strict_mode,
   input logic [TIME_W-1:0]            now_time,
   input logic [PORTS-1:0]             req_valid,
   input logic [PORTS-1:0]             req_write,
   input logic [PORTS-1:0]             req_ready,
   input logic [PORTS-1:0]             rsp_valid,
   input logic [PORTS-1:0][TIME_W-1:0] rsp_time,
   input logic                         fill_req,
   input logic [ADDR_W-1:0]            fill_addr,
   input logic                         fill_valid,
   input logic [PORTS-1:0]             hit_live
);
   a_r2_one_grant: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(req_ready));

   a_r7_fill_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (fill_req && !fill_valid) |=> (fill_req && $stable(fill_addr)));

   a_r7_quiet_fill: assert property (@(posedge clk) disable iff (!rst_n)
      fill_req |-> (req_ready == '0));

   for (genvar p = 0; p < PORTS; p++) begin : g_chk
      a_r4_no_live_write: assert property (@(posedge clk) disable iff (!rst_n)
         (req_valid[p] && req_ready[p] && req_write[p] && strict_mode) |-> !hit_live[p]);

      a_r5_time_ahead: assert property (@(posedge clk) disable iff (!rst_n)
         (req_valid[p] && req_ready[p] && req_write[p])
         |=> (rsp_valid[p] && rsp_time[p] >= $past(now_time)));

      a_r3_rsp_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
         rsp_valid[p] |-> $past(req_valid[p] && req_ready[p]));
   end
endmodule

bind lease_l2_ctrl lease_l2_chk #(
   .PORTS(PORTS), .ADDR_W(ADDR_W), .TIME_W(TIME_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .strict_mode(strict_mode),
   .now_time   (now_time),
   .req_valid  (req_valid),
   .req_write  (req_write),
   .req_ready  (req_ready),
   .rsp_valid  (rsp_valid),
   .rsp_time   (rsp_time),
   .fill_req   (fill_req),
   .fill_addr  (fill_addr),
   .fill_valid (fill_valid),
   .hit_live   (p_live)
);

// File: tb/tb_lease_l2_ctrl.sv
`timescale 1ns/1ps
module tb_lease_l2_ctrl;
   logic                 clk = 1'b0;
   logic                 rst_n = 1'b0;
   logic                 strict_mode = 1'b0;
   logic [15:0]          now_time = '0;
   logic [1:0]           req_valid = '0, req_write = '0;
   logic [1:0][7:0]      req_addr = '0;
   logic [1:0][15:0]     req_lease = '0;
   logic [1:0][7:0]      req_wdata = '0;
   logic [1:0]           req_ready, rsp_valid;
   logic [1:0][7:0]      rsp_data;
   logic [1:0][15:0]     rsp_time;
   logic                 fill_req, fill_valid, wb_valid;
   logic [7:0]           fill_addr, fill_data, wb_addr, wb_data;

   int n_chk = 0, n_bad = 0, wb_cnt = 0;
   logic [7:0] last_fill = '0, wb_a = '0, wb_d = '0;

   always #10 clk = ~clk;   // 50 MHz

   lease_l2_ctrl dut (
      .clk(clk), .rst_n(rst_n), .strict_mode(strict_mode), .now_time(now_time),
      .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
      .req_lease(req_lease), .req_wdata(req_wdata), .req_ready(req_ready),
      .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_time(rsp_time),
      .fill_req(fill_req), .fill_addr(fill_addr), .fill_valid(fill_valid),
      .fill_data(fill_data), .wb_valid(wb_valid), .wb_addr(wb_addr), .wb_data(wb_data)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // memory side: answers every fill two cycles later with addr ^ A5
   initial begin
      int cnt;
      cnt = 0;
      fill_valid = 1'b0;
      fill_data  = '0;
      forever begin
         @(negedge clk);
         fill_valid = 1'b0;
         if (fill_req) begin
            cnt++;
            if (cnt == 2) begin
               fill_valid = 1'b1;
               fill_data  = fill_addr ^ 8'hA5;
               last_fill  = fill_addr;
               cnt = 0;
            end
         end else cnt = 0;
      end
   end

   initial forever begin
      @(negedge clk);
      if (wb_valid) begin
         wb_cnt++;
         wb_a = wb_addr;
         wb_d = wb_data;
      end
   end

   task automatic do_req(input int p, input bit wr, input logic [7:0] a, input logic [15:0] l,
                         input logic [7:0] d, output logic [7:0] rd, output logic [15:0] rt,
                         output logic rv);
      @(negedge clk);
      req_valid[p] = 1'b1; req_write[p] = wr; req_addr[p] = a;
      req_lease[p] = l;    req_wdata[p] = d;
      forever begin
         #1;
         if (req_ready[p]) break;
         @(negedge clk);
      end
      @(posedge clk);
      @(negedge clk);
      req_valid[p] = 1'b0;
      rv = rsp_valid[p];
      rd = rsp_data[p];
      rt = rsp_time[p];
   endtask

   typedef struct packed {
      logic        port;
      logic        wr;
      logic [7:0]  addr;
      logic [15:0] lease;
      logic [7:0]  wdata;
      logic [15:0] now;
      logic [7:0]  exp_data;
      logic [15:0] exp_time;
   } vec_t;

   localparam int NV = 8;
   localparam vec_t VECS [NV] = '{
      '{1'b0, 1'b0, 8'h11, 16'd40, 8'h00, 16'd10, 8'hB4, 16'd40},  // R7 miss+fill, R3
      '{1'b1, 1'b0, 8'h11, 16'd30, 8'h00, 16'd12, 8'hB4, 16'd40},  // R3 lease below ts
      '{1'b0, 1'b1, 8'h11, 16'd0,  8'h5C, 16'd14, 8'h5C, 16'd40},  // R5 live -> ts
      '{1'b1, 1'b0, 8'h11, 16'd50, 8'h00, 16'd15, 8'h5C, 16'd50},  // R3 extend
      '{1'b0, 1'b1, 8'h11, 16'd0,  8'h33, 16'd60, 8'h33, 16'd60},  // R5 expired -> now
      '{1'b1, 1'b0, 8'h22, 16'd70, 8'h00, 16'd61, 8'h87, 16'd70},  // R7 miss port 1
      '{1'b0, 1'b1, 8'h22, 16'd0,  8'h9E, 16'd62, 8'h9E, 16'd70},  // R5 live
      '{1'b0, 1'b0, 8'h07, 16'd5,  8'h00, 16'd63, 8'hA2, 16'd5}    // R3 past lease
   };

   initial begin
      #(20 * 100000);
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin
      logic [7:0]  rd;
      logic [15:0] rt;
      logic        rv;
      repeat (3) @(posedge clk);
      @(negedge clk);
      check("R1 ready", req_ready, 0);
      check("R1 rsp_valid", rsp_valid, 0);
      check("R1 fill_req", fill_req, 0);
      check("R1 wb_valid", wb_valid, 0);
      rst_n = 1'b1;

      for (int i = 0; i < NV; i++) begin
         now_time = VECS[i].now;
         do_req(int'(VECS[i].port), VECS[i].wr, VECS[i].addr, VECS[i].lease,
                VECS[i].wdata, rd, rt, rv);
         check($sformatf("R3/R5/R7 vec%0d valid", i), rv, 1);
         check($sformatf("R3/R5/R7 vec%0d data", i), rd, VECS[i].exp_data);
         check($sformatf("R3/R5/R7 vec%0d time", i), rt, VECS[i].exp_time);
      end

      // R2: both ports present, port 0 wins first
      @(negedge clk);
      now_time = 16'd64;
      req_valid = 2'b11; req_write = 2'b00;
      req_addr[0] = 8'h11; req_addr[1] = 8'h22;
      req_lease[0] = 16'd0; req_lease[1] = 16'd0;
      #1 check("R2 port0 first", req_ready, 2'b01);
      @(posedge clk); @(negedge clk);
      req_valid[0] = 1'b0;
      check("R2 port0 rsp data", rsp_data[0], 8'h33);
      #1 check("R2 port1 next", req_ready, 2'b10);
      @(posedge clk); @(negedge clk);
      req_valid[1] = 1'b0;
      check("R2 port1 rsp data", rsp_data[1], 8'h9E);

      // R4/R6: strict hold on a live block
      strict_mode = 1'b1;
      now_time = 16'd100;
      do_req(1, 1'b0, 8'h11, 16'd130, 8'h00, rd, rt, rv);
      check("R3 lease 130", rt, 16'd130);
      @(negedge clk);
      now_time = 16'd122;
      req_valid[0] = 1'b1; req_write[0] = 1'b1; req_addr[0] = 8'h11; req_wdata[0] = 8'h6D;
      req_valid[1] = 1'b1; req_write[1] = 1'b0; req_addr[1] = 8'h11; req_lease[1] = 16'd200;
      #1 check("R4 write held", req_ready[0], 0);
      check("R6 same block held", req_ready[1], 0);
      @(negedge clk);
      #1 check("R6 same block still held", {req_ready[1], rsp_valid[1]}, 0);
      req_valid[1] = 1'b0;
      do_req(1, 1'b0, 8'h22, 16'd140, 8'h00, rd, rt, rv);
      check("R6 other block served", {rv, rd}, {1'b1, 8'h9E});
      check("R6 other block lease", rt, 16'd140);
      now_time = 16'd130;
      #1 check("R4 boundary now==ts held", req_ready[0], 0);
      @(negedge clk);
      now_time = 16'd131;
      #1 check("R4 released", req_ready[0], 1);
      @(posedge clk); @(negedge clk);
      req_valid[0] = 1'b0;
      check("R4 rsp time", rsp_time[0], 16'd131);
      check("R4 rsp data", rsp_data[0], 8'h6D);
      do_req(1, 1'b0, 8'h11, 16'd0, 8'h00, rd, rt, rv);
      check("R4 write landed", {rd, rt}, {8'h6D, 16'd130});

      // R8/R9: set 3 full of live leases
      strict_mode = 1'b0;
      now_time = 16'd200;
      do_req(0, 1'b0, 8'h03, 16'd300, 8'h00, rd, rt, rv);
      do_req(0, 1'b0, 8'h0B, 16'd300, 8'h00, rd, rt, rv);
      do_req(0, 1'b0, 8'h13, 16'd250, 8'h00, rd, rt, rv);
      do_req(0, 1'b0, 8'h1B, 16'd300, 8'h00, rd, rt, rv);
      check("R8 empty ways no writeback", wb_cnt, 0);
      @(negedge clk);
      now_time = 16'd210;
      req_valid[0] = 1'b1; req_write[0] = 1'b0; req_addr[0] = 8'h23; req_lease[0] = 16'd400;
      for (int k = 0; k < 4; k++) begin
         #1 check("R9 no fill while all live", {fill_req, req_ready[0]}, 0);
         @(negedge clk);
      end
      req_valid[0] = 1'b0;
      now_time = 16'd251;
      do_req(0, 1'b0, 8'h23, 16'd400, 8'h00, rd, rt, rv);
      check("R9 served after expiry", {rd, rt}, {8'h86, 16'd400});
      check("R8 one writeback", wb_cnt, 1);
      check("R8 expired way chosen", {wb_a, wb_d}, {8'h13, 8'hB6});
      check("R7 fill address", last_fill, 8'h23);

      // R10: fresh block is not live
      strict_mode = 1'b1;
      now_time = 16'd260;
      do_req(0, 1'b1, 8'h04, 16'd0, 8'h44, rd, rt, rv);
      check("R10 fresh write time", {rv, rd, rt}, {1'b1, 8'h44, 16'd260});

      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end
endmodule